// File: doc/BRIEF.md
# Receive Buffer with Line Status Flags

This block sits between a serial deserializer and a processor bus. Each time the deserializer finishes a character, it raises a one-cycle strobe with the data byte and a tag that says whether the parity check failed. The block stores the character, together with its tag, in a 64-entry first-in first-out buffer. With the buffer disabled, it stores the character in a single holding slot instead. The processor pops characters through a receive-buffer read port. It reads a line-status byte that reports data availability, lost characters and parity trouble.

The status byte is built from internal state, so it can be sampled at any time. A status read strobe clears the sticky overrun flag. It also acknowledges the parity flag of the head character. A parity tag is shown only while its character is at the head, so the flag always matches the byte the processor will read next. When storage is full, a new character is dropped and the stored data is kept. A reset strobe for the receive buffer empties the storage in one cycle.

Top module: `uart_rx_linestat`

## Requirements
- R1: After reset the status byte reads 0x60 and the buffer output reads 0x00. Bit 6 (transmitter empty) and bit 5 (transmit request) are always 1, and bits 4 and 3 are always 0.
- R2: With `fifo_en` high, up to 64 characters are returned in arrival order. Status bit 0 (data ready) is 1 while at least one character is stored and becomes 0 once the last one has been popped.
- R3: With `fifo_en` high and 64 characters stored, a character that arrives without a pop in the same cycle is discarded. Status bit 1 (overrun) is set, and the stored contents stay unchanged.
- R4: With `fifo_en` low, only one character is held. A second character that arrives before the held one is popped is lost and sets bit 1.
- R5: Status bit 2 (parity error) is 1 when the head character carries a failed-parity tag and no status read has happened since it became the head. A status read clears it, and a pop shows the next head's tag.
- R6: A status read clears bit 1. An overrun in the same cycle as a status read leaves bit 1 set.
- R7: A pulse on `rxfifo_clr` empties the storage and clears bit 0 on the next cycle. A character arriving in that same cycle is discarded, and bit 1 is left unchanged.
- R8: A pop while the storage is empty leaves the buffer output at the last popped byte and changes nothing in the status.
- R9: Status bit 7 (FIFO error) is 1 in buffered mode while any stored character carries a failed-parity tag. In single-slot mode it is always 0.
- R10: A change of `fifo_en` empties the storage on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Received byte failed its parity check |
| fifo_en | input | 1 | 1 selects the 64-entry buffer, 0 the single slot |
| rxfifo_clr | input | 1 | Empty the receive storage |
| rbr_rd | input | 1 | Pop the head character |
| rbr_data | output | 8 | Head character, or the last popped byte when empty |
| lsr_rd | input | 1 | Status read strobe; clears overrun and acknowledges parity |
| lsr | output | 8 | Line status byte |

## Verification
In-order bursts separate correct pointer wrap from lost or duplicated entries. Filling to exactly 64 and then adding one more shows whether a design drops the newest byte or overwrites old data. Parity tags placed at the second and fourth positions of a burst show whether the flag follows the head or the most recent arrival. Same-cycle combinations (overrun with a status read, reset with an arrival, pop while empty, and a mode toggle with data stored) check the priority rules that a plain sequence of reads and writes never reaches.

// File: rtl/uart_rx_linestat.sv
module uart_rx_linestat #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              fifo_en,
  input  logic              rxfifo_clr,
  input  logic              rbr_rd,
  output logic [DATA_W-1:0] rbr_data,
  input  logic              lsr_rd,
  output logic [7:0]        lsr
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_N = (AW+1)'(DEPTH);

  logic [DATA_W:0]   mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       count, err_cnt;
  logic [DATA_W-1:0] last_q;
  logic              fifo_en_q, oe_q, ack_q;

  logic              flush, empty, full, pop, ovr_evt, push, head_tag, push_tag, pop_tag;
  logic [AW:0]       cap;

  assign flush    = rxfifo_clr | (fifo_en != fifo_en_q);
  assign empty    = (count == '0);
  assign cap      = fifo_en ? FULL_N : (AW+1)'(1);
  assign full     = (count == cap);
  assign pop      = rbr_rd & ~empty & ~flush;
  assign ovr_evt  = rx_valid & ~flush & full & ~pop;
  assign push     = rx_valid & ~flush & ~ovr_evt;
  assign head_tag = mem[rd_ptr][DATA_W];
  assign push_tag = push & rx_perr;
  assign pop_tag  = pop & head_tag;

  assign rbr_data = empty ? last_q : mem[rd_ptr][DATA_W-1:0];
  assign lsr = {fifo_en_q & (err_cnt != '0), 2'b11, 2'b00,
                ~empty & head_tag & ~ack_q, oe_q, ~empty};

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {rx_perr, rx_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      err_cnt   <= '0;
      last_q    <= '0;
      fifo_en_q <= 1'b0;
      oe_q      <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en;
      oe_q      <= (oe_q & ~lsr_rd) | ovr_evt;
      if (flush) begin
        wr_ptr  <= '0;
        rd_ptr  <= '0;
        count   <= '0;
        err_cnt <= '0;
        ack_q   <= 1'b0;
      end else begin
        if (push) wr_ptr <= wr_ptr + 1'b1;
        if (pop) begin
          rd_ptr <= rd_ptr + 1'b1;
          last_q <= mem[rd_ptr][DATA_W-1:0];
        end
        count   <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
        err_cnt <= err_cnt + {{AW{1'b0}}, push_tag} - {{AW{1'b0}}, pop_tag};
        if (pop)                 ack_q <= 1'b0;
        else if (lsr_rd & ~empty) ack_q <= 1'b1;
      end
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_N);
  assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !flush && full && !rbr_rd) |=> (oe_q && $stable(count)));
  assert_single_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !fifo_en_q) |=> count <= (AW+1)'(1));
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && lsr_rd) |=> lsr[1]);
  assert_clr_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rxfifo_clr |=> (count == '0 && !lsr[0]));
  assert_clr_keeps_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxfifo_clr && oe_q && !lsr_rd) |=> lsr[1]);
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && empty && !rx_valid && !flush) |=> $stable(rbr_data));
  assert_toggle_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != fifo_en_q) |=> empty);
endmodule

// File: tb/sim_uart_rx_linestat.sv
module sim_uart_rx_linestat;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_perr = 0, fifo_en = 0, rxfifo_clr = 0, rbr_rd = 0, lsr_rd = 0;
  logic [7:0] rx_data = 0, rbr_data, lsr;
  int checks = 0, failures = 0, cyc = 0;
  string req = "R1";

  logic [8:0] q[$];
  logic [7:0] m_last;
  logic m_ack, m_oe, m_fen;

  always #2 clk = ~clk;

  uart_rx_linestat u0 (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .fifo_en(fifo_en), .rxfifo_clr(rxfifo_clr), .rbr_rd(rbr_rd),
    .rbr_data(rbr_data), .lsr_rd(lsr_rd), .lsr(lsr));

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_last = 0; m_ack = 0; m_oe = 0; m_fen = 0;
    end else begin
      bit chg, pop, ovr;
      chg = (fifo_en != m_fen);
      m_fen = fifo_en;
      ovr = 0;
      if (rxfifo_clr || chg) begin
        q.delete(); m_ack = 0;
      end else begin
        pop = rbr_rd && q.size() > 0;
        ovr = rx_valid && q.size() == (fifo_en ? 64 : 1) && !pop;
        if (pop) begin m_last = q[0][7:0]; void'(q.pop_front()); m_ack = 0; end
        else if (lsr_rd && q.size() > 0) m_ack = 1;
        if (rx_valid && !ovr) q.push_back({rx_perr, rx_data});
      end
      if (lsr_rd) m_oe = 0;
      if (ovr) m_oe = 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog %s actual=hung expected=done", req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (rst_n) begin
      logic [7:0] e_rbr, e_lsr;
      bit anyerr;
      anyerr = 0;
      foreach (q[i]) if (q[i][8]) anyerr = 1;
      e_rbr = (q.size() == 0) ? m_last : q[0][7:0];
      e_lsr = {m_fen & anyerr, 2'b11, 2'b00,
               q.size() > 0 && q[0][8] && !m_ack, m_oe, q.size() > 0};
      checks++;
      if (rbr_data !== e_rbr || lsr !== e_lsr) begin
        failures++;
        $display("FAIL %s rbr=%h lsr=%h expected rbr=%h lsr=%h", req, rbr_data, lsr, e_rbr, e_lsr);
      end
    end
  end

  task automatic step(input bit v, input logic [7:0] d, input bit pe,
                      input bit rd, input bit sr, input bit clr);
    @(negedge clk); #1;
    rx_valid = v; rx_data = d; rx_perr = pe; rbr_rd = rd; lsr_rd = sr; rxfifo_clr = clr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    req = "R1"; idle(3);
    req = "R10"; fifo_en = 1; idle(2);
    req = "R2";
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0);
    step(1, 8'hA5, 0, 1, 0, 0); step(1, 8'h5A, 0, 1, 0, 0); idle(1);
    for (int i = 0; i < 2; i++) step(0, 0, 0, 1, 0, 0);
    req = "R3";
    for (int i = 0; i < 64; i++) step(1, 8'(i * 3), 0, 0, 0, 0);
    step(1, 8'hEE, 0, 0, 0, 0); idle(1);
    step(1, 8'hEF, 0, 1, 0, 0);
    req = "R6"; step(1, 8'hF0, 0, 0, 1, 0); idle(1); step(0, 0, 0, 0, 1, 0); idle(1);
    req = "R3"; for (int i = 0; i < 66; i++) step(0, 0, 0, 1, 0, 0);
    req = "R5";
    for (int i = 0; i < 5; i++) step(1, 8'h30 + 8'(i), (i == 1 || i == 3), 0, 0, 0);
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0); idle(1);
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0);
    req = "R9"; idle(1); step(0, 0, 0, 1, 0, 0); idle(1);
    req = "R5"; step(0, 0, 0, 1, 1, 0); step(1, 8'h77, 1, 0, 1, 0); idle(2);
    req = "R7";
    for (int i = 0; i < 64; i++) step(1, 8'h40 + 8'(i), i[0], 0, 0, 0);
    step(1, 8'h99, 0, 0, 0, 0); step(1, 8'h98, 1, 0, 0, 1); idle(2);
    step(0, 0, 0, 0, 1, 0);
    req = "R8"; step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0); idle(2);
    req = "R4"; fifo_en = 0; idle(2);
    step(1, 8'hC1, 1, 0, 0, 0); step(1, 8'hC2, 0, 0, 0, 0); idle(1);
    step(1, 8'hC3, 0, 1, 0, 0); step(0, 0, 0, 1, 1, 0); idle(1);
    req = "R10"; step(1, 8'hD1, 0, 0, 0, 0); idle(1); fifo_en = 1; idle(2);
    step(1, 8'hD2, 1, 0, 0, 0); step(1, 8'hD3, 0, 0, 0, 0); idle(1);
    fifo_en = 0; idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule